// File: doc/BRIEF.md
# Floating-Point Multiply Operand Front End

This block is the first stage of a binary floating-point multiplier. It accepts one pair of operands per valid/ready handshake and does one of two things. If the pair is special, it settles the product at once and returns a finished result with an exception code and an invalid flag. Otherwise it returns a prepared operand bundle for the mantissa stage. The bundle holds the product sign, a signed destination exponent, and two significands with the leading one at the hidden-bit position. The multiply array and the rounding logic that follow are separate blocks.

Subnormal inputs are normalized one left shift per clock. Both operands are shifted in the same cycles and share one destination exponent, which is reduced by one for every shift of either operand. The input is not ready while a transaction is in progress. The rounding mode and the trap-enable vector are captured at accept and returned with the result, so the later stages see the settings that belong to this product. The defaults give IEEE double precision: 11 exponent bits, 52 fraction bits, and a 13-bit signed destination exponent.

Top module: `fmul_front`

## Requirements
- R1: Every result that is not a NaN carries the exclusive OR of the two operand signs. This covers the zero and infinity results and the bundle sign.
- R2: Infinity times zero, in either order, is invalid. If trap-enable bit 0 is set, the block returns exception code 1, a clear invalid flag and an all-zero result. If bit 0 is clear, it returns exception code 0, sets the invalid flag, and returns the default quiet NaN: sign 0, exponent all ones, fraction with only its top bit set.
- R3: NaN inputs are resolved in a fixed order. A fraction whose top bit is 0 marks a signaling NaN, and quieting sets that bit. A signaling NaN in operand A wins first. If there is none, a signaling NaN in operand B wins. If there is none, a quiet NaN in A is returned unchanged. If A is infinity and B is a NaN, the result is B's NaN. A signaling NaN takes the R2 trap-or-flag path and its payload is returned quieted. A quiet NaN alone raises nothing.
- R4: Infinity times a non-zero value that is not a NaN gives an infinity with the R1 sign, exception code 0 and no flag.
- R5: Zero (exponent and fraction both zero) times a finite value gives a zero with the R1 sign, exception code 0 and no flag.
- R6: The bundle exponent is the sum of the two biased exponent fields minus the bias (2^(EXP_W-1)-1), less one for each normalizing shift. It is carried as a signed value of EXP_W+2 bits. A subnormal contributes an exponent field of 0.
- R7: A normal operand's significand is its fraction with a 1 placed at bit FRAC_W.
- R8: A subnormal operand's significand is its fraction shifted left once, then shifted left one place per clock until bit FRAC_W is 1. Each shift lowers the shared exponent by one.
- R9: For every transaction, out_valid is a single-cycle pulse. It appears s+1 clock edges after the accepting edge, where s is the larger shift count of the two operands. An early result has s = 0. in_ready stays low from the accepting edge until after the pulse.
- R10: The bundle returns the rounding mode and the trap-enable vector that were presented with the accepted operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle and able to accept |
| op_a | input | 1+EXP_W+FRAC_W | Operand A, sign/exponent/fraction |
| op_b | input | 1+EXP_W+FRAC_W | Operand B |
| trap_en | input | TRAP_W | Trap enables; bit 0 enables the invalid trap |
| rnd_mode | input | 2 | Rounding mode, passed to later stages |
| out_valid | output | 1 | One-cycle result strobe |
| out_early | output | 1 | 1: early_* fields carry the finished result |
| early_res | output | 1+EXP_W+FRAC_W | Finished special-case result |
| early_exc | output | 2 | 0 none, 1 invalid trap taken |
| flag_invalid | output | 1 | Invalid flag raised without trap |
| prod_sign | output | 1 | Product sign |
| prod_exp | output | EXP_W+2 | Signed destination exponent |
| sig_a | output | FRAC_W+1 | Normalized significand of A |
| sig_b | output | FRAC_W+1 | Normalized significand of B |
| out_rnd_mode | output | 2 | Rounding mode of this transaction |
| out_trap_en | output | TRAP_W | Trap enables of this transaction |

## Verification
The bench uses a 4-bit exponent and a 4-bit fraction. It pairs every operand value with a spread of partners plus every special class, so it covers every subnormal shift depth against every other class.

The NaN ordering cases target a design that picks the wrong payload or skips the quieting step. The sharpest of these is infinity paired with a NaN in operand B. Zero-times-infinity in both orders, with the trap on and off, exposes a flag raised together with a trap, or a trap that is ignored. Pairs of two subnormals check that both shifters run together. A design that shifted them one after the other, or dropped one exponent decrement, would show a latency or exponent mismatch.

// File: rtl/fmf_pkg.sv
package fmf_pkg;

    // Operand classes produced by the classifier
    typedef enum logic [2:0] {
        CL_ZERO = 3'd0,
        CL_SUB  = 3'd1,
        CL_NORM = 3'd2,
        CL_INF  = 3'd3,
        CL_QNAN = 3'd4,
        CL_SNAN = 3'd5
    } opcls_e;

    // Exception code returned with an early result
    typedef enum logic [1:0] {
        EXC_NONE    = 2'd0,
        EXC_INVALID = 2'd1
    } exc_e;

    // Transaction sequencer
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_NORM = 2'd1,
        ST_DONE = 2'd2
    } fstate_e;

    // Control part of a resolved special case
    typedef struct packed {
        logic hit;
        exc_e exc;
        logic flag;
    } early_ctl_t;

    // Position of the invalid-trap enable in the trap vector
    localparam int TRAP_INV_BIT = 0;

    function automatic logic is_nan_cls(opcls_e c);
        return (c == CL_QNAN) || (c == CL_SNAN);
    endfunction

endpackage

// File: rtl/fmf_classify.sv
module fmf_classify
    import fmf_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] op,
    output opcls_e                cls,
    output logic [FRAC_W:0]       sig_init
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;
    logic              ex_max, ex_min, fr_zero;

    assign ex      = op[W-2:FRAC_W];
    assign fr      = op[FRAC_W-1:0];
    assign ex_max  = &ex;
    assign ex_min  = ~|ex;
    assign fr_zero = ~|fr;

    always_comb begin
        if (ex_max) begin
            if (fr_zero)             cls = CL_INF;
            else if (fr[FRAC_W-1])   cls = CL_QNAN;
            else                     cls = CL_SNAN;
        end else if (ex_min) begin
            cls = fr_zero ? CL_ZERO : CL_SUB;
        end else begin
            cls = CL_NORM;
        end
    end

    // Starting significand: hidden one for normals, one pre-shift for subnormals
    always_comb begin
        unique case (cls)
            CL_NORM: sig_init = {1'b1, fr};
            CL_SUB:  sig_init = {fr, 1'b0};
            default: sig_init = '0;
        endcase
    end

endmodule

// File: rtl/fmf_special.sv
module fmf_special
    import fmf_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    input  opcls_e                cls_a,
    input  opcls_e                cls_b,
    input  logic                  inv_trap,
    output early_ctl_t            ctl,
    output logic [EXP_W+FRAC_W:0] res
);
    localparam int W = 1 + EXP_W + FRAC_W;
    localparam logic [W-1:0] QMASK    = W'(1) << (FRAC_W - 1);
    localparam logic [W-1:0] DEF_QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic          sgn;
    logic          a_inf, b_inf, a_nan, b_nan, a_zero, b_zero;
    logic          raise;
    logic [W-1:0]  val;
    logic          hit;

    assign sgn    = op_a[W-1] ^ op_b[W-1];
    assign a_inf  = (cls_a == CL_INF);
    assign b_inf  = (cls_b == CL_INF);
    assign a_nan  = is_nan_cls(cls_a);
    assign b_nan  = is_nan_cls(cls_b);
    assign a_zero = (cls_a == CL_ZERO);
    assign b_zero = (cls_b == CL_ZERO);

    // Priority chain: A infinite, A NaN, B infinite, B NaN, zero
    always_comb begin
        hit   = 1'b0;
        raise = 1'b0;
        val   = '0;
        if (a_inf && !b_nan) begin
            hit = 1'b1;
            if (b_zero) begin
                raise = 1'b1;
                val   = DEF_QNAN;
            end else begin
                val = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            end
        end else if (a_nan) begin
            hit = 1'b1;
            if (cls_a == CL_SNAN) begin
                raise = 1'b1;
                val   = op_a | QMASK;
            end else if (cls_b == CL_SNAN) begin
                raise = 1'b1;
                val   = op_b | QMASK;
            end else begin
                val = op_a;
            end
        end else if (b_inf) begin
            hit = 1'b1;
            if (a_zero) begin
                raise = 1'b1;
                val   = DEF_QNAN;
            end else begin
                val = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            end
        end else if (b_nan) begin
            hit   = 1'b1;
            raise = (cls_b == CL_SNAN);
            val   = op_b | QMASK;
        end else if (a_zero || b_zero) begin
            hit = 1'b1;
            val = {sgn, {(W-1){1'b0}}};
        end
    end

    // Trap takes the invalid case without touching the flag
    always_comb begin
        ctl.hit  = hit;
        ctl.exc  = EXC_NONE;
        ctl.flag = 1'b0;
        res      = val;
        if (raise) begin
            if (inv_trap) begin
                ctl.exc = EXC_INVALID;
                res     = '0;
            end else begin
                ctl.flag = 1'b1;
            end
        end
    end

    always_comb begin
        assert_trap_noflag_R2: assert (!(ctl.exc == EXC_INVALID && ctl.flag));
        assert_exc_needs_hit_R3: assert (ctl.exc == EXC_NONE || ctl.hit);
    end

endmodule

// File: rtl/fmf_norm.sv
module fmf_norm #(
    parameter int FRAC_W = 52
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [FRAC_W:0] sig_load,
    input  logic            step,
    output logic [FRAC_W:0] sig,
    output logic            done
);
    assign done = sig[FRAC_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            sig <= '0;
        end else if (load) begin
            sig <= sig_load;
        end else if (step && !done) begin
            sig <= {sig[FRAC_W-1:0], 1'b0};
        end
    end

    assert_hold_when_done_R8: assert property (@(posedge clk) disable iff (rst)
        (!load && done) |=> $stable(sig));

    assert_lead_rises_R8: assert property (@(posedge clk) disable iff (rst)
        (!load && step && !done && sig[FRAC_W-1]) |=> done);

endmodule

// File: rtl/fmul_front.sv
module fmul_front
    import fmf_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int TRAP_W = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [EXP_W+FRAC_W:0]     op_a,
    input  logic [EXP_W+FRAC_W:0]     op_b,
    input  logic [TRAP_W-1:0]         trap_en,
    input  logic [1:0]                rnd_mode,
    output logic                      out_valid,
    output logic                      out_early,
    output logic [EXP_W+FRAC_W:0]     early_res,
    output logic [1:0]                early_exc,
    output logic                      flag_invalid,
    output logic                      prod_sign,
    output logic signed [EXP_W+1:0]   prod_exp,
    output logic [FRAC_W:0]           sig_a,
    output logic [FRAC_W:0]           sig_b,
    output logic [1:0]                out_rnd_mode,
    output logic [TRAP_W-1:0]         out_trap_en
);
    localparam int W      = 1 + EXP_W + FRAC_W;
    localparam int DEXP_W = EXP_W + 2;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int N_OP   = 2;

    fstate_e state;
    logic    accept;

    logic [W-1:0]      ops      [N_OP];
    opcls_e            cls      [N_OP];
    logic [FRAC_W:0]   sig_init [N_OP];
    logic [FRAC_W:0]   sig_cur  [N_OP];
    logic [N_OP-1:0]   done_v;
    logic [N_OP-1:0]   init_hid;
    logic [N_OP-1:0]   next_done;

    early_ctl_t        sp_ctl;
    logic [W-1:0]      sp_res;

    logic [DEXP_W-1:0] exp_sum;
    logic [DEXP_W-1:0] dec;

    logic              early_q, flag_q, sign_q;
    exc_e              exc_q;
    logic [W-1:0]      res_q;
    logic [DEXP_W-1:0] dexp_q;
    logic [1:0]        rm_q;
    logic [TRAP_W-1:0] te_q;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    assign in_ready = (state == ST_IDLE);
    assign accept   = in_valid && in_ready;

    // Per-operand classification and normalization
    for (genvar g = 0; g < N_OP; g++) begin : g_op
        fmf_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .op       (ops[g]),
            .cls      (cls[g]),
            .sig_init (sig_init[g])
        );

        fmf_norm #(.FRAC_W(FRAC_W)) u_norm (
            .clk      (clk),
            .rst      (rst),
            .load     (accept),
            .sig_load (sig_init[g]),
            .step     (state == ST_NORM),
            .sig      (sig_cur[g]),
            .done     (done_v[g])
        );

        assign init_hid[g]  = sig_init[g][FRAC_W];
        assign next_done[g] = done_v[g] || sig_cur[g][FRAC_W-1];
    end

    fmf_special #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_special (
        .op_a     (op_a),
        .op_b     (op_b),
        .cls_a    (cls[0]),
        .cls_b    (cls[1]),
        .inv_trap (trap_en[TRAP_INV_BIT]),
        .ctl      (sp_ctl),
        .res      (sp_res)
    );

    // Biased sum minus bias, two's complement in DEXP_W bits
    assign exp_sum = DEXP_W'(op_a[W-2:FRAC_W]) + DEXP_W'(op_b[W-2:FRAC_W]) - DEXP_W'(BIAS);

    // One exponent decrement per operand still shifting this cycle
    always_comb begin
        dec = '0;
        for (int i = 0; i < N_OP; i++) begin
            dec = dec + DEXP_W'(!done_v[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    state <= (sp_ctl.hit || (&init_hid)) ? ST_DONE : ST_NORM;
                end
                ST_NORM: if (&next_done) state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            early_q <= 1'b0;
            flag_q  <= 1'b0;
            sign_q  <= 1'b0;
            exc_q   <= EXC_NONE;
            res_q   <= '0;
            dexp_q  <= '0;
            rm_q    <= '0;
            te_q    <= '0;
        end else if (accept) begin
            early_q <= sp_ctl.hit;
            flag_q  <= sp_ctl.flag;
            exc_q   <= sp_ctl.exc;
            res_q   <= sp_res;
            sign_q  <= op_a[W-1] ^ op_b[W-1];
            dexp_q  <= exp_sum;
            rm_q    <= rnd_mode;
            te_q    <= trap_en;
        end else if (state == ST_NORM) begin
            dexp_q  <= dexp_q - dec;
        end
    end

    assign out_valid    = (state == ST_DONE);
    assign out_early    = early_q;
    assign early_res    = res_q;
    assign early_exc    = exc_q;
    assign flag_invalid = flag_q;
    assign prod_sign    = sign_q;
    assign prod_exp     = $signed(dexp_q);
    assign sig_a        = sig_cur[0];
    assign sig_b        = sig_cur[1];
    assign out_rnd_mode = rm_q;
    assign out_trap_en  = te_q;

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
        accept |=> !in_ready);

    assert_exp_falls_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_NORM) |=> ($signed(dexp_q) < $signed($past(dexp_q))));

    assert_hidden_set_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_early) |-> (sig_a[FRAC_W] && sig_b[FRAC_W]));

    assert_norm_live_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_NORM) |-> ((|sig_cur[0]) && (|sig_cur[1])));

    assert_mode_kept_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_NORM) |=> ($stable(rm_q) && $stable(te_q)));

endmodule

// File: tb/fmul_front_bench.sv
module fmul_front_bench;
    localparam int EW         = 4;
    localparam int FW         = 4;
    localparam int TW         = 5;
    localparam int W          = 1 + EW + FW;
    localparam int DW         = EW + 2;
    localparam int BIAS       = 7;
    localparam int EMAX       = 15;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          in_ready;
    logic [W-1:0]  op_a, op_b;
    logic [TW-1:0] trap_en;
    logic [1:0]    rnd_mode;
    logic          out_valid, out_early;
    logic [W-1:0]  early_res;
    logic [1:0]    early_exc;
    logic          flag_invalid;
    logic          prod_sign;
    logic signed [DW-1:0] prod_exp;
    logic [FW:0]   sig_a, sig_b;
    logic [1:0]    out_rnd_mode;
    logic [TW-1:0] out_trap_en;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fmul_front #(.EXP_W(EW), .FRAC_W(FW), .TRAP_W(TW)) u_fmul_front (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .op_a(op_a), .op_b(op_b), .trap_en(trap_en), .rnd_mode(rnd_mode),
        .out_valid(out_valid), .out_early(out_early), .early_res(early_res),
        .early_exc(early_exc), .flag_invalid(flag_invalid), .prod_sign(prod_sign),
        .prod_exp(prod_exp), .sig_a(sig_a), .sig_b(sig_b),
        .out_rnd_mode(out_rnd_mode), .out_trap_en(out_trap_en)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    // Left shifts needed after the first one to reach the hidden position
    function automatic int shifts_of(input logic [FW-1:0] f);
        int msb = 0;
        for (int i = 0; i < FW; i++) if (f[i]) msb = i;
        return FW - 1 - msb;
    endfunction

    task automatic run_pair(input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic [TW-1:0] te, input logic [1:0] rm);
        int ea, eb, fa, fb, sa, sb, lat, cnt, e_exp;
        bit a_zero, b_zero, a_sub, b_sub, a_inf, b_inf, a_nan, b_nan, a_sn, b_sn;
        bit sgn, e_early, e_flag, raise;
        int e_res, e_exc, e_siga, e_sigb;
        string tag;
        ea = int'(a[W-2:FW]); fa = int'(a[FW-1:0]);
        eb = int'(b[W-2:FW]); fb = int'(b[FW-1:0]);
        a_zero = (ea == 0 && fa == 0); a_sub = (ea == 0 && fa != 0);
        b_zero = (eb == 0 && fb == 0); b_sub = (eb == 0 && fb != 0);
        a_inf = (ea == EMAX && fa == 0); a_nan = (ea == EMAX && fa != 0);
        b_inf = (eb == EMAX && fb == 0); b_nan = (eb == EMAX && fb != 0);
        a_sn = a_nan && !a[FW-1];
        b_sn = b_nan && !b[FW-1];
        sgn = a[W-1] ^ b[W-1];
        e_early = 1'b1; raise = 1'b0; e_res = 0; tag = "R5";
        if (a_inf && !b_nan) begin
            if (b_zero) begin raise = 1'b1; e_res = 'h0F8; tag = "R2"; end
            else begin e_res = (int'(sgn) << 8) | 'h0F0; tag = "R4"; end
        end else if (a_nan) begin
            tag = "R3";
            if (a_sn) begin raise = 1'b1; e_res = int'(a) | 8; end
            else if (b_sn) begin raise = 1'b1; e_res = int'(b) | 8; end
            else e_res = int'(a);
        end else if (b_inf) begin
            if (a_zero) begin raise = 1'b1; e_res = 'h0F8; tag = "R2"; end
            else begin e_res = (int'(sgn) << 8) | 'h0F0; tag = "R4"; end
        end else if (b_nan) begin
            tag = "R3"; raise = b_sn; e_res = int'(b) | 8;
        end else if (a_zero || b_zero) begin
            e_res = int'(sgn) << 8; tag = "R5";
        end else begin
            e_early = 1'b0;
        end
        e_exc = 0; e_flag = 1'b0;
        if (raise) begin
            if (te[0]) begin e_exc = 1; e_res = 0; end
            else e_flag = 1'b1;
        end
        sa = a_sub ? shifts_of(a[FW-1:0]) : 0;
        sb = b_sub ? shifts_of(b[FW-1:0]) : 0;
        e_siga = a_sub ? (fa << (1 + sa)) : (16 | fa);
        e_sigb = b_sub ? (fb << (1 + sb)) : (16 | fb);
        e_exp  = ea + eb - BIAS - sa - sb;
        lat    = e_early ? 1 : 1 + ((sa > sb) ? sa : sb);

        op_a = a; op_b = b; trap_en = te; rnd_mode = rm; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        cnt = 1;
        while (!out_valid && cnt < 20) begin
            check(in_ready == 1'b0, "R9", "ready while busy", int'(in_ready), 0);
            @(negedge clk);
            cnt++;
        end
        check(in_ready == 1'b0, "R9", "ready at strobe", int'(in_ready), 0);
        check(cnt == lat, "R9", "latency", cnt, lat);
        check(out_early == e_early, tag, "early select", int'(out_early), int'(e_early));
        if (e_early) begin
            check(int'(early_res) == e_res, tag, "early result", int'(early_res), e_res);
            check(int'(early_exc) == e_exc, tag, "exception code", int'(early_exc), e_exc);
            check(flag_invalid == e_flag, tag, "invalid flag", int'(flag_invalid), int'(e_flag));
            if (!a_nan && !b_nan && !raise)
                check(early_res[W-1] == sgn, "R1", "early sign", int'(early_res[W-1]), int'(sgn));
        end else begin
            check(prod_sign == sgn, "R1", "bundle sign", int'(prod_sign), int'(sgn));
            check(int'(prod_exp) == e_exp, "R6", "exponent", int'(prod_exp), e_exp);
            check(int'(sig_a) == e_siga, a_sub ? "R8" : "R7", "sig A", int'(sig_a), e_siga);
            check(int'(sig_b) == e_sigb, b_sub ? "R8" : "R7", "sig B", int'(sig_b), e_sigb);
            check(out_rnd_mode == rm, "R10", "rounding mode", int'(out_rnd_mode), int'(rm));
            check(out_trap_en == te, "R10", "trap vector", int'(out_trap_en), int'(te));
        end
        @(negedge clk);
        check(out_valid == 1'b0, "R9", "strobe width", int'(out_valid), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [W-1:0] extra [10];
        extra[0] = 9'h000; extra[1] = 9'h100; extra[2] = 9'h0F0; extra[3] = 9'h1F0;
        extra[4] = 9'h0F9; extra[5] = 9'h0F3; extra[6] = 9'h1F1; extra[7] = 9'h001;
        extra[8] = 9'h10F; extra[9] = 9'h0E7;
        rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0; trap_en = '0; rnd_mode = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(out_valid == 1'b0, "R9", "reset strobe", int'(out_valid), 0);
        check(in_ready == 1'b1, "R9", "reset ready", int'(in_ready), 1);
        @(negedge clk);
        for (int ai = 0; ai < (1 << W); ai++) begin
            for (int bi = 0; bi < (1 << W); bi += 17) begin
                run_pair(W'(ai), W'(bi), TW'(ai ^ (bi >> 1)), 2'(ai + bi));
            end
            for (int k = 0; k < 10; k++) begin
                run_pair(W'(ai), extra[k], TW'(ai >> k), 2'(k));
                run_pair(extra[k], W'(ai), TW'(~ai), 2'(ai));
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule